// File: doc/BRIEF.md
# Dual down-counting timer

This peripheral holds two independent 32-bit down-counting timers behind a single word-addressed register interface. Each timer has its own bank of registers: a live count, a load value, a background load value, a control word, a raw expiry flag and a masked interrupt flag. It also drives its own interrupt output. Counting is paced by a clock-enable `tick` input. A running timer decrements by one on each tick. On the tick where the count is already zero, the timer expires and sets its raw flag. It then either reloads from the load value and keeps running (periodic), or stops (one-shot).

Software starts a timer by writing the control word with the enable bit set. This copies the load value into the count. Writing the load value while the timer is enabled restarts the count at once. Writing the background load value changes the reload value without disturbing the count in progress, so a new period takes effect at the next expiry. The raw flag is cleared by writing a one to it. The interrupt output and the masked flag are both the raw flag gated by the control word's interrupt-enable bit.

The two register banks sit back to back, each eight words wide. Bank 0 occupies word addresses 0..7 and bank 1 occupies 8..15. Reads of any other location return zero, and writes to them change nothing.

Top module: `dual_dtimer`

## Requirements
- R1: After reset every readable location returns 0, both timers are stopped and both `irq` bits are 0.
- R2: Timer i's bank starts at word address i*8. Inside a bank the word offsets are: 0 live count, 1 load value, 2 background load, 3 control, 4 raw flag (bit 0), 5 masked flag (bit 0). Offsets 6 and 7, and any address of 16 or above, read 0, and writes to them change no state.
- R3: Control bit 0 is enable, bit 1 is one-shot (0 = periodic) and bit 2 is interrupt enable. Control reads back bits 2:0 with all upper bits 0. A control write with bit 0 set loads the count from the load value and starts counting. A control write with bit 0 clear stops counting and the count holds.
- R4: While running, each tick decrements the count by one. A tick on which the count is 0 is an expiry: it sets the raw flag, and in periodic mode it reloads the count from the load value. A periodic timer loaded with L therefore expires once every L+1 ticks, and with L = 0 it expires on every tick.
- R5: In one-shot mode an expiry leaves the count at 0 and stops the timer. Further ticks change nothing until a control write, or a load write while enabled.
- R6: A load-value write stores the value. If control bit 0 is set, the count restarts from the new value in the next cycle. If bit 0 is clear, the count is unaffected.
- R7: A background-load write sets both the background and the load value, leaves the running count untouched, and the new value is used at the next reload.
- R8: Writing raw flag bit 0 as 1 clears the flag; writing it as 0 leaves it unchanged. When an expiry and a clear fall in the same cycle, the flag ends up set.
- R9: The masked flag and `irq[i]` both equal the raw flag ANDed with control bit 2. `irq` rises only after a tick or a write, and falls only after a write.
- R10: Writes to the live count offset and the masked flag offset are ignored.
- R11: The two timers are independent: activity on one never changes the other's registers or count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable; one decrement step per asserted cycle |
| bus_addr | input | ADDR_W (5) | Word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | CNT_W (32) | Write data |
| bus_rdata | output | CNT_W (32) | Read data for `bus_addr`, combinational |
| irq | output | N_TIMERS (2) | Per-timer interrupt, raw flag AND interrupt enable |

## Verification
On every cycle the assertions check the following:
- Each `irq` bit is cleared one cycle after a write-one to its raw flag.
- Each `irq` bit rises only after a tick or a write, and falls only after a write.
- A read of the masked offset returns exactly the corresponding `irq` bit.
- Reads outside both banks return zero.

Other behaviours can only be shown by the bench's scenarios. These are the count sequence and reload period for a sweep of load values in both modes on both timers, the one-shot stop, restart on a load write, the deferred effect of a background load, the priority of a set over a clear, and the isolation between the two banks.

// File: rtl/dtm_pkg.sv
package dtm_pkg;
   // word offsets inside one timer bank (software-visible layout)
   localparam int unsigned OFF_COUNT = 0;
   localparam int unsigned OFF_LOAD  = 1;
   localparam int unsigned OFF_BG    = 2;
   localparam int unsigned OFF_CTRL  = 3;
   localparam int unsigned OFF_RAW   = 4;
   localparam int unsigned OFF_MASK  = 5;
   // control word bit positions
   localparam int unsigned CB_EN     = 0;
   localparam int unsigned CB_ONE    = 1;
   localparam int unsigned CB_IE     = 2;
   localparam int unsigned CTRL_W    = 3;
endpackage

// File: rtl/dtm_addr_dec.sv
module dtm_addr_dec #(
   parameter int unsigned ADDR_W   = 5,
   parameter int unsigned OFF_W    = 3,
   parameter int unsigned N_TIMERS = 2
) (
   input  logic [ADDR_W-1:0]   addr,
   output logic [OFF_W-1:0]    off,
   output logic [N_TIMERS-1:0] sel
);
   localparam int unsigned BANK_W = ADDR_W - OFF_W;

   logic [BANK_W-1:0] bank;

   assign bank = addr[ADDR_W-1:OFF_W];
   assign off  = addr[OFF_W-1:0];

   for (genvar i = 0; i < N_TIMERS; i++) begin : g_sel
      assign sel[i] = (bank == BANK_W'(i));
   end
endmodule

// File: rtl/dtm_channel.sv
module dtm_channel
   import dtm_pkg::*;
#(
   parameter int unsigned CNT_W = 32,
   parameter int unsigned OFF_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             wr_en,
   input  logic [OFF_W-1:0] off,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] rd_data,
   output logic             irq
);
   localparam logic [OFF_W-1:0] O_COUNT = OFF_W'(OFF_COUNT);
   localparam logic [OFF_W-1:0] O_LOAD  = OFF_W'(OFF_LOAD);
   localparam logic [OFF_W-1:0] O_BG    = OFF_W'(OFF_BG);
   localparam logic [OFF_W-1:0] O_CTRL  = OFF_W'(OFF_CTRL);
   localparam logic [OFF_W-1:0] O_RAW   = OFF_W'(OFF_RAW);
   localparam logic [OFF_W-1:0] O_MASK  = OFF_W'(OFF_MASK);

   logic [CNT_W-1:0]  cnt_q, load_q, bg_q;
   logic [CTRL_W-1:0] ctl_q;
   logic              run_q, raw_q;
   logic              w_load, w_bg, w_ctl, w_raw, expire;

   assign w_load = wr_en && (off == O_LOAD);
   assign w_bg   = wr_en && (off == O_BG);
   assign w_ctl  = wr_en && (off == O_CTRL);
   assign w_raw  = wr_en && (off == O_RAW);
   assign expire = tick && run_q && (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         load_q <= '0;
         bg_q   <= '0;
         ctl_q  <= '0;
         run_q  <= 1'b0;
         raw_q  <= 1'b0;
      end else begin
         if (w_load) load_q <= wr_data;
         if (w_bg) begin
            bg_q   <= wr_data;
            load_q <= wr_data;
         end
         if (w_ctl) ctl_q <= wr_data[CTRL_W-1:0];

         // count and run state: a register write outranks a tick
         if (w_ctl) begin
            if (wr_data[CB_EN]) begin
               cnt_q <= load_q;
               run_q <= 1'b1;
            end else begin
               run_q <= 1'b0;
            end
         end else if (w_load && ctl_q[CB_EN]) begin
            cnt_q <= wr_data;
            run_q <= 1'b1;
         end else if (tick && run_q) begin
            if (cnt_q == '0) begin
               if (ctl_q[CB_ONE]) run_q <= 1'b0;
               else               cnt_q <= load_q;
            end else begin
               cnt_q <= cnt_q - 1'b1;
            end
         end

         // raw flag: a set outranks a clear
         if (expire)                  raw_q <= 1'b1;
         else if (w_raw && wr_data[0]) raw_q <= 1'b0;
      end
   end

   assign irq = raw_q & ctl_q[CB_IE];

   always_comb begin
      unique case (off)
         O_COUNT: rd_data = cnt_q;
         O_LOAD:  rd_data = load_q;
         O_BG:    rd_data = bg_q;
         O_CTRL:  rd_data = CNT_W'(ctl_q);
         O_RAW:   rd_data = CNT_W'(raw_q);
         O_MASK:  rd_data = CNT_W'(irq);
         default: rd_data = '0;
      endcase
   end
endmodule

// File: rtl/dual_dtimer.sv
module dual_dtimer #(
   parameter int unsigned CNT_W      = 32,
   parameter int unsigned N_TIMERS   = 2,
   parameter int unsigned BANK_WORDS = 8,
   parameter int unsigned ADDR_W     = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_we,
   input  logic [CNT_W-1:0]    bus_wdata,
   output logic [CNT_W-1:0]    bus_rdata,
   output logic [N_TIMERS-1:0] irq
);
   localparam int unsigned OFF_W = $clog2(BANK_WORDS);

   // elaboration-time parameter checks
   if (BANK_WORDS < 6 || (BANK_WORDS & (BANK_WORDS - 1)) != 0) begin : g_bad_bank
      $error("BANK_WORDS must be a power of two of at least 6");
   end
   if (ADDR_W <= OFF_W || N_TIMERS * BANK_WORDS > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too small for N_TIMERS banks");
   end
   if (CNT_W < dtm_pkg::CTRL_W || N_TIMERS < 1) begin : g_bad_cnt
      $error("CNT_W or N_TIMERS out of range");
   end

   logic [OFF_W-1:0]    off;
   logic [N_TIMERS-1:0] sel;
   logic [CNT_W-1:0]    ch_rd [N_TIMERS];

   dtm_addr_dec #(
      .ADDR_W  (ADDR_W),
      .OFF_W   (OFF_W),
      .N_TIMERS(N_TIMERS)
   ) dec_i (
      .addr(bus_addr),
      .off (off),
      .sel (sel)
   );

   for (genvar i = 0; i < N_TIMERS; i++) begin : g_ch
      dtm_channel #(
         .CNT_W(CNT_W),
         .OFF_W(OFF_W)
      ) ch_i (
         .clk    (clk),
         .rst_n  (rst_n),
         .tick   (tick),
         .wr_en  (bus_we && sel[i]),
         .off    (off),
         .wr_data(bus_wdata),
         .rd_data(ch_rd[i]),
         .irq    (irq[i])
      );
   end

   always_comb begin
      bus_rdata = '0;
      for (int i = 0; i < N_TIMERS; i++) begin
         if (sel[i]) bus_rdata = bus_rdata | ch_rd[i];
      end
   end
endmodule

// File: rtl/dtm_checker.sv
module dtm_checker #(
   parameter int unsigned CNT_W      = 32,
   parameter int unsigned N_TIMERS   = 2,
   parameter int unsigned BANK_WORDS = 8,
   parameter int unsigned ADDR_W     = 5
) (
   input logic                clk,
   input logic                rst_n,
   input logic                tick,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic                bus_we,
   input logic                wd0,
   input logic [CNT_W-1:0]    bus_rdata,
   input logic [N_TIMERS-1:0] irq
);
   a_r1_irq_low_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (irq == '0));

   a_r2_outside_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(bus_addr) >= N_TIMERS * BANK_WORDS) |-> (bus_rdata == '0));

   for (genvar i = 0; i < N_TIMERS; i++) begin : g_t
      a_r8_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_we && bus_addr == ADDR_W'(i * BANK_WORDS + 4) && wd0 && !tick) |=> !irq[i]);

      a_r9_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(irq[i]) |-> $past(tick || bus_we));

      a_r9_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(irq[i]) |-> $past(bus_we));

      a_r9_mask_read: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_addr == ADDR_W'(i * BANK_WORDS + 5)) |-> (bus_rdata == CNT_W'(irq[i])));
   end
endmodule

bind dual_dtimer dtm_checker #(
   .CNT_W     (CNT_W),
   .N_TIMERS  (N_TIMERS),
   .BANK_WORDS(BANK_WORDS),
   .ADDR_W    (ADDR_W)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick     (tick),
   .bus_addr (bus_addr),
   .bus_we   (bus_we),
   .wd0      (bus_wdata[0]),
   .bus_rdata(bus_rdata),
   .irq      (irq)
);

// File: tb/dual_dtimer_tb_top.sv
`timescale 1ns/1ps
module dual_dtimer_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [1:0]  irq;

   int n_chk = 0;
   int n_fail = 0;
   int cycles = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   dual_dtimer dut_i (
      .clk(clk), .rst_n(rst_n), .tick(tick), .bus_addr(bus_addr),
      .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   always @(posedge clk) begin
      cycles++;
      if (cycles >= 60000 && !done) begin
         done = 1;
         n_fail++;
         $display("FAIL watchdog: run did not finish, act=%0d exp<60000", cycles);
         $display("  [TB] %0d tests run, %0d failed", n_chk + 1, n_fail);
         $finish;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: act=0x%08h exp=0x%08h", req, act, exp);
      end
   endtask

   // drive one clock cycle from a negedge to the next negedge
   task automatic cyc(input logic tk, input logic w, input logic [4:0] a, input logic [31:0] d);
      tick = tk; bus_we = w; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      tick = 1'b0; bus_we = 1'b0;
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      cyc(1'b0, 1'b1, a, d);
   endtask

   task automatic tk1();
      cyc(1'b1, 1'b0, 5'd0, 32'd0);
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] v);
      tick = 1'b0; bus_we = 1'b0; bus_addr = a;
      #0.5;
      v = bus_rdata;
   endtask

   initial begin
      logic [31:0] v, hold0;
      int lv[5] = '{0, 1, 2, 3, 6};

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      for (int a = 0; a < 16; a++) begin
         rd(5'(a), v);
         check("R1 reset read", v, 32'd0);
      end
      check("R1 reset irq", 32'(irq), 32'd0);

      // R4/R9 periodic sweep and R5 one-shot sweep on both timers
      for (int t = 0; t < 2; t++) begin
         logic [4:0] b;
         b = 5'(t * 8);
         if (t == 1) begin
            rd(5'd0, hold0);
         end
         foreach (lv[k]) begin
            int L;
            L = lv[k];
            wr(b + 5'd3, 32'd0);
            wr(b + 5'd4, 32'd1);
            wr(b + 5'd1, 32'(L));
            wr(b + 5'd3, 32'd5);
            rd(b, v);
            check("R3 start loads count", v, 32'(L));
            for (int j = 1; j <= 2 * L + 3; j++) begin
               tk1();
               rd(b, v);
               check("R4 periodic count", v, 32'(L - (j % (L + 1))));
               rd(b + 5'd4, v);
               check("R4 raw after expiry", v, 32'(j >= L + 1));
               check("R9 irq periodic", 32'(irq[t]), 32'(j >= L + 1));
            end
            wr(b + 5'd3, 32'd0);
            wr(b + 5'd4, 32'd1);
            wr(b + 5'd3, 32'd7);
            rd(b + 5'd3, v);
            check("R3 ctrl readback", v, 32'd7);
            for (int j = 1; j <= L + 3; j++) begin
               tk1();
               rd(b, v);
               check("R5 one-shot count", v, (j <= L) ? 32'(L - j) : 32'd0);
               rd(b + 5'd5, v);
               check("R9 masked one-shot", v, 32'(j > L));
            end
            wr(b + 5'd3, 32'd0);
            wr(b + 5'd4, 32'd1);
         end
         if (t == 1) begin
            rd(5'd0, v);
            check("R11 timer0 untouched by timer1", v, hold0);
         end
      end

      // R3 hold on disable, upper control bits read 0
      wr(5'd1, 32'd20);
      wr(5'd3, 32'hFFFF_FFF9);
      rd(5'd3, v);
      check("R3 ctrl upper bits zero", v, 32'd1);
      tk1(); tk1(); tk1();
      wr(5'd3, 32'd0);
      tk1(); tk1();
      rd(5'd0, v);
      check("R3 disabled count holds", v, 32'd17);

      // R6 load write while disabled / enabled
      wr(5'd1, 32'd4);
      rd(5'd0, v);
      check("R6 disabled load no restart", v, 32'd17);
      wr(5'd3, 32'd1);
      tk1(); tk1();
      wr(5'd1, 32'd9);
      rd(5'd0, v);
      check("R6 enabled load restarts", v, 32'd9);

      // R7 background load
      wr(5'd1, 32'd5);
      tk1(); tk1();
      wr(5'd2, 32'd2);
      rd(5'd0, v);
      check("R7 bg keeps count", v, 32'd3);
      rd(5'd1, v);
      check("R7 bg sets load", v, 32'd2);
      rd(5'd2, v);
      check("R7 bg readback", v, 32'd2);
      tk1(); tk1(); tk1(); tk1();
      rd(5'd0, v);
      check("R7 new value at reload", v, 32'd2);

      // R10 ignored writes
      wr(5'd0, 32'h1234);
      wr(5'd5, 32'hFFFF_FFFF);
      rd(5'd0, v);
      check("R10 count write ignored", v, 32'd2);
      rd(5'd5, v);
      check("R10 mask write ignored", v, 32'd0);

      // R8 write-one-to-clear and set priority
      wr(5'd3, 32'd0);
      wr(5'd1, 32'd0);
      wr(5'd3, 32'd5);
      tk1();
      wr(5'd4, 32'd0);
      rd(5'd4, v);
      check("R8 write 0 keeps flag", v, 32'd1);
      cyc(1'b1, 1'b1, 5'd4, 32'd1);
      rd(5'd4, v);
      check("R8 set beats clear", v, 32'd1);
      wr(5'd4, 32'd1);
      rd(5'd4, v);
      check("R8 write 1 clears", v, 32'd0);
      check("R9 irq cleared", 32'(irq[0]), 32'd0);

      // R9 interrupt enable gating
      wr(5'd3, 32'd1);
      tk1();
      rd(5'd5, v);
      check("R9 masked off without enable", v, 32'd0);
      check("R9 irq off without enable", 32'(irq[0]), 32'd0);
      wr(5'd3, 32'd4);
      check("R9 irq on with enable", 32'(irq[0]), 32'd1);
      wr(5'd4, 32'd1);

      // R2 unused offsets and out-of-range addresses
      wr(5'd1, 32'd33);
      wr(5'd6, 32'hAAAA_5555);
      wr(5'd15, 32'h5555_AAAA);
      rd(5'd6, v);
      check("R2 unused offset reads 0", v, 32'd0);
      rd(5'd15, v);
      check("R2 unused offset bank1 reads 0", v, 32'd0);
      for (int a = 16; a < 32; a++) begin
         wr(5'(a), 32'hFFFF_FFFF);
         rd(5'(a), v);
         check("R2 outside reads 0", v, 32'd0);
      end
      rd(5'd1, v);
      check("R2 outside write no effect t0", v, 32'd33);
      rd(5'd3, v);
      check("R2 outside write no effect ctrl", v, 32'd4);
      rd(5'd11, v);
      check("R2 outside write no effect t1", v, 32'd0);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule